// File: doc/BRIEF.md
# Quarter-Square Table Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product without forming partial products. It uses the identity a·b = ⌊(a+b)²/4⌋ − ⌊|a−b|²/4⌋. One single-port table of squares divided by four serves both lookups, and the lookups happen one after the other. Dropping the remainder of each quarter square is exact. a+b and a−b always have the same parity, so both squares leave the same remainder modulo 4, and the two remainders cancel.

A caller presents both operands and raises `start` while the block is idle. The state machine has three states. IDLE moves to SUM_LOOKUP when `start` is seen. SUM_LOOKUP always moves to DIFF_LOOKUP, and DIFF_LOOKUP always returns to IDLE. In SUM_LOOKUP the table is addressed by the 9-bit sum, whose carry forms the top index bit, and the entry is loaded into the result register. In DIFF_LOOKUP the table is addressed by the magnitude of the difference, and that entry is subtracted from the held value one byte lane at a time with a borrow chain. `done` then pulses for one cycle while the product is valid. The table contents are computed at elaboration by a constant function, so the block needs no initialisation file.

Top module: `qsq_mult`

## Requirements
- R1: In the cycle where `done` is high, `product` equals op_a × op_b as a full 16-bit value, using the operands captured when `start` was accepted. The product then holds while the block is idle.
- R2: Operand pairs whose sum carries out of 8 bits give correct products. These use table indices from 256 up to 510, for example 255×255 = 65025 and 255×1 = 255.
- R3: When op_a < op_b, the difference is negated to its magnitude before the lookup, and the product is still correct. The byte-wise subtraction never borrows out of the top lane.
- R4: A `start` seen while idle is accepted at that clock edge. `busy` is then high for exactly two cycles: SUM_LOOKUP followed by DIFF_LOOKUP.
- R5: `done` is a one-cycle pulse in the cycle right after DIFF_LOOKUP, which is three clock edges after acceptance counted from the accepting edge. `done` and `busy` are never high together.
- R6: `start` raised while `busy` is high is ignored. It does not change the product in progress and it does not begin an extra operation.
- R7: Operand inputs are sampled only at the accepting edge. Changing them while busy has no effect on the product.
- R8: Synchronous active-high `rst` returns the state machine to IDLE and clears `product` and `done` to zero, including when it arrives during an operation.
- R9: If `start` is held high continuously, a new operation is accepted in every done cycle. Each operation takes three cycles, and every one of them produces a correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiply; taken only when idle |
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| busy | output | 1 | High during SUM_LOOKUP and DIFF_LOOKUP |
| done | output | 1 | One-cycle pulse with the product valid |
| product | output | 16 | Unsigned product register |

## Verification
On every cycle, the assertions check the fixed SUM_LOOKUP → DIFF_LOOKUP → done order, the single-cycle width of `done`, and that `done` and `busy` are never high together. They also check that the captured operands stay put while busy, that the top byte lane never borrows, and that the product equals the captured operands multiplied. Only the bench scenarios can show the rest. Those are the behaviour at the ports when inputs are changed or `start` is re-raised during an operation, a reset that arrives in mid-operation, and back-to-back acceptance when `start` is held high. An exhaustive sweep over all 65,536 operand pairs covers every table entry that is reachable.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

    // width of one lane in the byte-wise subtractor
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUM  = 2'd1,
        ST_DIFF = 2'd2
    } qsq_state_e;

endpackage

// File: rtl/qsq_index.sv
// Forms the table index: the widened sum, or the magnitude of the difference.
module qsq_index #(
    parameter int OP_W  = 8,
    localparam int IDX_W = OP_W + 1
) (
    input  logic [OP_W-1:0]  opa,
    input  logic [OP_W-1:0]  opb,
    input  logic             use_diff,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] sum_w;
    logic [IDX_W-1:0] dif_w;
    logic             borrow;
    logic [OP_W-1:0]  mag;

    always_comb begin
        sum_w  = {1'b0, opa} + {1'b0, opb};
        dif_w  = {1'b0, opa} - {1'b0, opb};
        borrow = dif_w[OP_W];
        if (borrow) begin
            mag = OP_W'(~dif_w[OP_W-1:0] + 1'b1);
        end else begin
            mag = dif_w[OP_W-1:0];
        end
        idx = use_diff ? {1'b0, mag} : sum_w;
    end

endmodule

// File: rtl/qsq_rom.sv
// Single-port table of floor(i*i/4), built at elaboration.
module qsq_rom #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic [IDX_W-1:0]  addr,
    output logic [DATA_W-1:0] rd_data
);

    function automatic logic [DATA_W-1:0] quarter_sq(input int i);
        return DATA_W'((i * i) >> 2);
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign mem[g] = quarter_sq(g);
    end

    assign rd_data = mem[addr];

endmodule

// File: rtl/qsq_lanesub.sv
// Lane-by-lane subtraction with a rippling borrow.
module qsq_lanesub #(
    parameter int RES_W = 16,
    localparam int LW    = qsq_pkg::LANE_W,
    localparam int LANES = RES_W / LW
) (
    input  logic [RES_W-1:0] minuend,
    input  logic [RES_W-1:0] subtrahend,
    output logic [RES_W-1:0] diff,
    output logic             borrow_out
);

    logic [LANES:0] brw;
    assign brw[0] = 1'b0;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LW:0] t;
        assign t = {1'b0, minuend[k*LW +: LW]}
                 - {1'b0, subtrahend[k*LW +: LW]}
                 - {{LW{1'b0}}, brw[k]};
        assign diff[k*LW +: LW] = t[LW-1:0];
        assign brw[k+1]         = t[LW];
    end

    assign borrow_out = brw[LANES];

endmodule

// File: rtl/qsq_mult.sv
module qsq_mult
    import qsq_pkg::*;
#(
    parameter int OP_W  = 8,
    localparam int IDX_W = OP_W + 1,
    localparam int RES_W = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] product
);

    qsq_state_e       state_q, state_d;
    logic [OP_W-1:0]  opa_q, opb_q;
    logic [RES_W-1:0] product_q;
    logic             done_q;
    logic [IDX_W-1:0] tab_idx;
    logic [RES_W-1:0] tab_data;
    logic [RES_W-1:0] sub_out;
    logic             sub_borrow;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SUM;
            ST_SUM:  state_d = ST_DIFF;
            ST_DIFF: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q     <= '0;
            opb_q     <= '0;
            product_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        opa_q <= op_a;
                        opb_q <= op_b;
                    end
                end
                ST_SUM: product_q <= tab_data;
                ST_DIFF: begin
                    product_q <= sub_out;
                    done_q    <= 1'b1;
                end
                default: done_q <= 1'b0;
            endcase
        end
    end

    qsq_index #(.OP_W(OP_W)) u_index (
        .opa      (opa_q),
        .opb      (opb_q),
        .use_diff (state_q == ST_DIFF),
        .idx      (tab_idx)
    );

    qsq_rom #(.IDX_W(IDX_W), .DATA_W(RES_W)) u_rom (
        .addr    (tab_idx),
        .rd_data (tab_data)
    );

    qsq_lanesub #(.RES_W(RES_W)) u_sub (
        .minuend    (product_q),
        .subtrahend (tab_data),
        .diff       (sub_out),
        .borrow_out (sub_borrow)
    );

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign product = product_q;

    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == RES_W'(opa_q) * RES_W'(opb_q))); // R1
    AST_NO_TOP_BORROW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIFF) |-> !sub_borrow); // R3
    AST_SUM_THEN_DIFF: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUM) |=> (state_q == ST_DIFF)); // R4
    AST_DIFF_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIFF) |=> (done && !busy)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R5
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(opa_q) && $stable(opb_q))); // R6

endmodule

// File: tb/tb_qsq_mult.sv
module tb_qsq_mult;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic        busy, done;
    logic [15:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    int ph       = 0;
    int ea       = 0;
    int eb       = 0;
    int m_res    = 0;
    bit m_done   = 1'b0;
    bit mon_en   = 1'b0;
    int done_seen = 0;

    always #5 clk = ~clk;

    qsq_mult dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_a    (a),
        .op_b    (b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // behavioural reference: phase counter and expected product
    always @(posedge clk) begin
        if (rst) begin
            ph = 0; m_res = 0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            case (ph)
                0: if (start) begin ea = int'(a); eb = int'(b); ph = 1; end
                1: ph = 2;
                default: begin m_res = ea * eb; m_done = 1'b1; ph = 0; end
            endcase
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            chk(busy == (ph != 0), "R4 busy", int'(busy), int'(ph != 0));
            chk(done == m_done, "R5 done", int'(done), int'(m_done));
            if (ph == 0) chk(int'(product) == m_res, "R1 product", int'(product), m_res);
            if (done) done_seen++;
        end
    end

    task automatic run_op(input int x, input int y, input string tag);
        @(negedge clk);
        a = 8'(x); b = 8'(y); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(done && int'(product) == x * y, tag, int'(product), x * y);
    endtask

    initial begin
        repeat (199500) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int d0;
        @(posedge clk);
        mon_en = 1'b1;
        @(negedge clk);
        chk(!busy && !done && product == 16'd0, "R8 reset state", int'(product), 0);
        @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // carry into index bit 8
        run_op(255, 255, "R2 255x255");
        run_op(255, 1,   "R2 255x1");
        run_op(128, 128, "R2 128x128");
        run_op(0, 0,     "R1 0x0");
        run_op(13, 11,   "R1 13x11");
        // borrow path: a < b
        run_op(3, 200,   "R3 3x200");
        run_op(0, 255,   "R3 0x255");
        run_op(254, 255, "R3 254x255");

        // R6: start re-raised during busy
        @(negedge clk); a = 8'd10; b = 8'd20; start = 1'b1;
        @(negedge clk); a = 8'd99; b = 8'd99;
        @(negedge clk);
        @(negedge clk); start = 1'b0;
        chk(done && product == 16'd200, "R6 ignored start", int'(product), 200);
        @(negedge clk);
        chk(!busy, "R6 no extra op", int'(busy), 0);

        // R7: operands changed while busy
        @(negedge clk); a = 8'd7; b = 8'd9; start = 1'b1;
        @(negedge clk); start = 1'b0; a = 8'd200; b = 8'd1;
        @(negedge clk); a = 8'd5;
        @(negedge clk);
        chk(done && product == 16'd63, "R7 operands latched", int'(product), 63);

        // R8: reset in mid-operation
        @(negedge clk); a = 8'd200; b = 8'd200; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && product == 16'd0, "R8 mid-op reset", int'(product), 0);
        rst = 1'b0;

        // R9 + R1: exhaustive sweep with start held high
        d0 = done_seen;
        for (int i = 0; i < 65536; i++) begin
            a = 8'(i >> 8); b = 8'(i); start = 1'b1;
            @(negedge clk);
            while (ph != 0) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(done_seen - d0 == 65536, "R9 back-to-back count", done_seen - d0, 65536);

        summary();
        $finish;
    end

endmodule